// File: doc/BRIEF.md
# LCD Common Multiplex Timing Generator

This block generates the row scan timing for a multiplexed dot-matrix LCD. It counts oscillator ticks, which arrive as a one-cycle strobe on the system clock, into fixed-length row periods. It then steps a row counter through one frame. At every moment it drives exactly one common select line high, and it gives the segment datapath the current row index so that the matching pixel data can be fetched.

Every frame opens with an icon row and closes with a second icon row. The text rows sit between the two. In long duty the frame has 21 text rows and 23 rows in total. In short duty it has only 14 text rows and 16 rows in total. The duty request can change at any time. It takes effect at the next frame boundary, so a frame is never cut short.

A frame polarity flag toggles once per frame, which gives the line-inversion drive used to keep DC off the panel. A power-down input forces every common select to the off state. Any character blinking elsewhere in the display takes its phase from a separate blink phase output, which toggles after a fixed number of oscillator ticks.

Top module: `lcd_com_scan`

## Requirements
- R1: When reset is released, row_idx_o is 0, com_sel_o equals 1 (only bit 0, the leading icon row, is set), frame_inv_o is 0, blink_o is 0, and the active duty is long.
- R2: Each row lasts ROW_CYCLES oscillator ticks. row_idx_o changes only on the clock edge at which the ROW_CYCLES-th tick of the row is seen. Clock cycles with osc_tick_i low do not advance the count.
- R3: In long duty the frame has NUM_COM+2 rows, with row_idx_o running 0 to NUM_COM+1. Row 0 selects com_sel_o bit 0 (leading icon row). Row k, for k from 1 to NUM_COM, selects bit k (text common k). Row NUM_COM+1 selects bit NUM_COM+1 (trailing icon row).
- R4: In short duty the frame has SHORT_COM+2 rows. Row 0 selects bit 0. Rows 1 to SHORT_COM select bits 1 to SHORT_COM. Row SHORT_COM+1 selects bit NUM_COM+1. Bits SHORT_COM+1 to NUM_COM never go high in this duty.
- R5: duty_long_i (1 = long, 0 = short) is sampled only on the edge at which the last row of a frame ends. A change earlier in a frame has no effect on that frame's length or its select sequence.
- R6: While power_down_i is 0, exactly one bit of com_sel_o is high.
- R7: While power_down_i is 1, com_sel_o is all zero in the same cycle. Row timing, row_idx_o and frame_inv_o keep running unaffected.
- R8: frame_inv_o toggles on the edge at which the last row of a frame ends, which is the same edge at which row_idx_o returns to 0. It holds its value at every other edge.
- R9: blink_o toggles on every BLINK_TICKS-th oscillator tick counted from reset, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle strobe per oscillator period |
| duty_long_i | input | 1 | Duty request: 1 long (NUM_COM+2 rows), 0 short (SHORT_COM+2 rows) |
| power_down_i | input | 1 | Forces all common selects off |
| com_sel_o | output | NUM_COM+2 | One-hot common select: bit 0 leading icon row, bits 1..NUM_COM text commons, top bit trailing icon row |
| row_idx_o | output | clog2(NUM_COM+2) | Position of the current row within the frame |
| frame_inv_o | output | 1 | Frame polarity flag |
| blink_o | output | 1 | Blink phase |

## Verification
A wrong row counter or a wrong latched duty shows up as a select bit in the wrong place. It can also show up as a frame that is too short or too long, or as a text common in the range SHORT_COM+1 to NUM_COM firing during short duty. This becomes visible at com_sel_o in the same cycle the counter goes wrong. A wrong tick prescaler shifts the row boundaries by at least one row period. A wrong polarity or blink counter inverts frame_inv_o or blink_o from one particular boundary onward. The bench uses random tick density, random duty and random power-down changes, which catch these within a few frames. Directed frame-length measurements pin the mid-frame duty change to the frame boundary.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic {
    DUTY_SHORT = 1'b0,
    DUTY_LONG  = 1'b1
  } duty_e;
endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer #(
  parameter int unsigned ROW_CYCLES = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  output logic row_end_o
);
  localparam int unsigned CNT_W = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign row_end_o = osc_tick_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (osc_tick_i) begin
      if (cnt_q == CNT_LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM   = 21,
  parameter int unsigned SHORT_COM = 14,
  parameter int unsigned ROW_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_end_i,
  input  duty_e            duty_req_i,
  output logic [ROW_W-1:0] row_o,
  output duty_e            duty_o,
  output logic             frame_inv_o
);
  localparam logic [ROW_W-1:0] LAST_LONG  = ROW_W'(NUM_COM + 1);
  localparam logic [ROW_W-1:0] LAST_SHORT = ROW_W'(SHORT_COM + 1);

  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] last_row;
  duty_e            duty_q;
  logic             inv_q;
  logic             frame_end;

  assign last_row  = (duty_q == DUTY_LONG) ? LAST_LONG : LAST_SHORT;
  assign frame_end = row_end_i && (row_q == last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      duty_q <= DUTY_LONG;
      inv_q  <= 1'b0;
    end else if (frame_end) begin
      row_q  <= '0;
      duty_q <= duty_req_i;
      inv_q  <= ~inv_q;
    end else if (row_end_i) begin
      row_q  <= row_q + 1'b1;
    end
  end

  assign row_o       = row_q;
  assign duty_o      = duty_q;
  assign frame_inv_o = inv_q;

  p_row_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= last_row);
  p_row_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_end_i |=> $stable(row_q) && $stable(inv_q));
  p_row_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_end_i && row_q != last_row) |=> (row_q == $past(row_q) + 1'b1) && $stable(inv_q));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_end_i && row_q == last_row) |=> (row_q == '0) && (inv_q != $past(inv_q)));
  p_duty_at_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_q) |-> row_q == '0);
endmodule

// File: rtl/lcd_com_decode.sv
module lcd_com_decode
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM   = 21,
  parameter int unsigned SHORT_COM = 14,
  parameter int unsigned ROW_W     = 5
) (
  input  logic               [ROW_W-1:0] row_i,
  input  duty_e                          duty_i,
  input  logic                           pd_i,
  output logic [NUM_COM+1:0]             sel_o
);
  localparam logic [ROW_W-1:0] LAST_LONG  = ROW_W'(NUM_COM + 1);
  localparam logic [ROW_W-1:0] LAST_SHORT = ROW_W'(SHORT_COM + 1);

  logic [NUM_COM+1:0] raw;
  logic               is_long;

  assign is_long = (duty_i == DUTY_LONG);

  assign raw[0] = (row_i == '0);
  assign raw[NUM_COM+1] = is_long ? (row_i == LAST_LONG) : (row_i == LAST_SHORT);

  for (genvar k = 1; k <= NUM_COM; k++) begin : g_text
    if (k <= SHORT_COM) begin : g_both
      assign raw[k] = (row_i == ROW_W'(k));
    end else begin : g_long_only
      assign raw[k] = is_long && (row_i == ROW_W'(k));
    end
  end

  assign sel_o = pd_i ? '0 : raw;
endmodule

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
  parameter int unsigned BLINK_TICKS = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  output logic blink_o
);
  localparam int unsigned BW = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
  localparam logic [BW-1:0] B_LAST = BW'(BLINK_TICKS - 1);

  logic [BW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (osc_tick_i) begin
      if (cnt_q == B_LAST) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign blink_o = ph_q;

  p_blink_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_tick_i |=> $stable(ph_q));
  p_blink_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= B_LAST);
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COM     = 21,
  parameter int unsigned SHORT_COM   = 14,
  parameter int unsigned ROW_CYCLES  = 110,
  parameter int unsigned BLINK_TICKS = 100000
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             osc_tick_i,
  input  logic                             duty_long_i,
  input  logic                             power_down_i,
  output logic [NUM_COM+1:0]               com_sel_o,
  output logic [$clog2(NUM_COM+2)-1:0]     row_idx_o,
  output logic                             frame_inv_o,
  output logic                             blink_o
);
  localparam int unsigned ROW_W = $clog2(NUM_COM + 2);

  logic             row_end;
  logic [ROW_W-1:0] row;
  duty_e            duty_act;

  lcd_row_timer #(.ROW_CYCLES(ROW_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .row_end_o  (row_end)
  );

  lcd_row_seq #(.NUM_COM(NUM_COM), .SHORT_COM(SHORT_COM), .ROW_W(ROW_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_end_i   (row_end),
    .duty_req_i  (duty_e'(duty_long_i)),
    .row_o       (row),
    .duty_o      (duty_act),
    .frame_inv_o (frame_inv_o)
  );

  lcd_com_decode #(.NUM_COM(NUM_COM), .SHORT_COM(SHORT_COM), .ROW_W(ROW_W)) u_dec (
    .row_i  (row),
    .duty_i (duty_act),
    .pd_i   (power_down_i),
    .sel_o  (com_sel_o)
  );

  lcd_blink_timer #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .blink_o    (blink_o)
  );

  assign row_idx_o = row;

  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_down_i |-> $countones(com_sel_o) == 1);
  p_pd_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_i |-> com_sel_o == '0);
  p_lead_icon_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row == '0 && !power_down_i) |-> com_sel_o[0]);
  p_short_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act == DUTY_SHORT) |-> com_sel_o[NUM_COM:SHORT_COM+1] == '0);
endmodule

// File: tb/lcd_com_scan_bench.sv
module lcd_com_scan_bench;
  localparam int NC  = 21;
  localparam int SC  = 14;
  localparam int RC  = 5;
  localparam int BT  = 37;
  localparam int NS  = NC + 2;
  localparam int RW  = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic duty_l = 1'b1;
  logic pd = 1'b0;
  logic [NS-1:0] sel;
  logic [RW-1:0] row_idx;
  logic inv, blink;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_com_scan #(.NUM_COM(NC), .SHORT_COM(SC), .ROW_CYCLES(RC), .BLINK_TICKS(BT)) u_lcd_com_scan (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .duty_long_i(duty_l),
    .power_down_i(pd), .com_sel_o(sel), .row_idx_o(row_idx),
    .frame_inv_o(inv), .blink_o(blink)
  );

  // reference model
  int m_cnt, m_row, m_bcnt;
  bit m_long, m_pol, m_blink;

  function automatic int last_row(bit lng);
    return lng ? NC + 1 : SC + 1;
  endfunction

  function automatic logic [NS-1:0] exp_sel(int r, bit lng, bit p);
    logic [NS-1:0] v = '0;
    if (p) return v;
    if (r == 0) v[0] = 1'b1;
    else if (r == last_row(lng)) v[NS-1] = 1'b1;
    else v[r] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_row = 0; m_bcnt = 0; m_long = 1; m_pol = 0; m_blink = 0;
    end else if (tick) begin
      if (m_cnt == RC - 1) begin
        m_cnt = 0;
        if (m_row == last_row(m_long)) begin
          m_row = 0; m_pol = ~m_pol; m_long = duty_l;
        end else m_row = m_row + 1;
      end else m_cnt = m_cnt + 1;
      if (m_bcnt == BT - 1) begin m_bcnt = 0; m_blink = ~m_blink; end
      else m_bcnt = m_bcnt + 1;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // continuous comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(m_long ? "R3 select" : "R4 select", 64'(sel), 64'(exp_sel(m_row, m_long, pd)));
      chk("R2 row index", 64'(row_idx), 64'(m_row));
      chk("R8 frame polarity", 64'(inv), 64'(m_pol));
      chk("R9 blink phase", 64'(blink), 64'(m_blink));
      if (!m_long) chk("R4 masked commons", 64'(sel[NC:SC+1]), 64'd0);
      if (!pd) chk("R6 one-hot", 64'($countones(sel)), 64'd1);
      else chk("R7 power-down off", 64'(sel), 64'd0);
    end
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // measure clk cycles of one complete frame with tick held high
  task automatic measure(output int len);
    logic p;
    p = inv;
    len = 0;
    while (inv == p) begin step(); len++; end
  endtask

  int len;
  logic [NS-1:0] seen;

  initial begin
    void'($urandom(32'h5eed_1cd0));
    repeat (3) step();
    @(negedge clk);
    chk("R1 reset select", 64'(sel), 64'd1);
    chk("R1 reset row", 64'(row_idx), 64'd0);
    chk("R1 reset polarity", 64'(inv), 64'd0);
    chk("R1 reset blink", 64'(blink), 64'd0);
    step();
    rst_n = 1'b1;
    // R2: no ticks, nothing moves
    repeat (20) step();
    @(negedge clk);
    chk("R2 idle row", 64'(row_idx), 64'd0);
    step();
    // R2: exactly RC ticks advance one row
    tick = 1'b1;
    repeat (RC - 1) step();
    @(negedge clk);
    chk("R2 before row end", 64'(row_idx), 64'd0);
    step();
    @(negedge clk);
    chk("R2 after row end", 64'(row_idx), 64'd1);
    step();
    // R3: long frame length
    duty_l = 1'b1;
    measure(len);
    measure(len);
    chk("R3 long frame length", 64'(len), 64'(NS * RC));
    // R4: switch to short, takes effect after this frame
    duty_l = 1'b0;
    measure(len);
    measure(len);
    chk("R4 short frame length", 64'(len), 64'((SC + 2) * RC));
    seen = '0;
    for (int i = 0; i < (SC + 2) * RC; i++) begin step(); seen |= sel; end
    chk("R4 commons seen in short", 64'(seen), 64'(((NS)'(1) << (NS-1)) | ((NS)'(1) << (SC+1)) - 1));
    // R5: mid-frame request does not shorten or lengthen the current frame
    measure(len);
    repeat (3) step();
    duty_l = 1'b1;
    len = 3;
    begin
      logic p = inv;
      while (inv == p) begin step(); len++; end
    end
    chk("R5 frame length after mid-frame change", 64'(len), 64'((SC + 2) * RC));
    measure(len);
    chk("R5 new duty applied next frame", 64'(len), 64'(NS * RC));
    // R7: power-down keeps timing running
    pd = 1'b1;
    measure(len);
    chk("R7 frame length under power-down", 64'(len), 64'(NS * RC));
    @(negedge clk);
    chk("R7 selects off", 64'(sel), 64'd0);
    step();
    pd = 1'b0;
    // random phase
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 300 == 0) duty_l = ~duty_l;
      if ($urandom % 200 == 0) pd = ~pd;
      step();
    end
    // R1: reset mid-operation
    rst_n = 1'b0;
    step();
    @(negedge clk);
    chk("R1 re-reset select", 64'(sel), 64'(pd ? 0 : 1));
    chk("R1 re-reset polarity", 64'(inv), 64'd0);
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule